// File: doc/BRIEF.md
# Periodic Entropy Refresh Requester

This block fetches fresh random material from an external entropy source over a simple request/acknowledge handshake and assembles it into a 128-bit reseed value. A refresh always consists of two 64-bit fetches issued back to back. The first word fills the low half of the value and the second word fills the high half. When the pair is complete, the assembled value is published and a one-cycle done pulse marks it.

The block sits idle after reset until an explicit start command arrives while it is enabled. That command triggers the first refresh immediately, and the block counts as initialised from then on. After each completed pair, an interval counter runs for the programmed number of cycles. When it expires, the next pair is fetched. The counter stays at zero while fetches are outstanding, so the spacing between refreshes is always measured from the end of the previous pair. Dropping the enable input abandons any pair in progress, throws away a half-collected word and returns the block to idle. A new start command is then needed.

The handshake is assumed to be synchronous to the block's clock. The typical interval is 256 cycles.

Top module: `reseed_requester`

## Requirements
- R1: During and right after reset, `req` and `seed_done` are low and `seed_out` is all zeros.
- R2: No request is raised before a start command. A one-cycle `start` pulse seen while `enable` is high makes `req` high from the next cycle.
- R3: Once raised, `req` stays high on every cycle until `ack` is sampled high, and `data_in` is captured in that same cycle.
- R4: The first acknowledged word of a pair becomes `seed_out[63:0]` and the second becomes `seed_out[127:64]`. `seed_out` updates and `seed_done` is high for exactly one cycle, starting the cycle after the second acknowledge.
- R5: After the first word of a pair is acknowledged, `req` is high again in the very next cycle, which is well within 20 cycles.
- R6: `req` rises exactly `interval` cycles after the rising edge of `seed_done`. An `interval` of 0 behaves as 1.
- R7: The interval counter is held at zero while a fetch is outstanding and restarts only when a pair completes. Slow acknowledges therefore never shorten the next wait.
- R8: `enable` low drops `req` in the next cycle and discards a half-collected pair. `seed_out` keeps the last complete value, and nothing is requested until a new `start` arrives with `enable` high. The pair after that start is built from two fresh words.
- R9: A `start` pulse while the block is already initialised has no effect: the current wait keeps its programmed length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Low aborts activity and returns to idle |
| start | input | 1 | Command that triggers the first refresh |
| interval | input | CNT_W | Wait in cycles between refreshes (0 acts as 1) |
| req | output | 1 | Entropy request, held until acknowledged |
| ack | input | 1 | Entropy source acknowledge, data valid with it |
| data_in | input | WORD_W | 64-bit entropy word |
| seed_out | output | 2*WORD_W | Last complete 128-bit reseed value |
| seed_done | output | 1 | One-cycle pulse when `seed_out` updates |

## Verification
The pairs are served with acknowledge delays of zero, one and three cycles. Each pair uses distinct word patterns, so a swapped half or a stale word shows up as a wrong value at the scoreboard.

The wait before the next pair is measured for intervals of 0, 1, 4, 5, 30 and 256. These values separate an off-by-one in the counter, the zero case and a counter that free-runs during the fetch.

A start pulse issued in the middle of a wait checks that the wait keeps its length. An abort after the first word checks that the half-collected word is discarded and that the block needs a new start command.

// File: rtl/reseed_pkg.sv
// Shared definitions for the entropy refresh requester.
// Assumes: one clock domain, handshake synchronous to it.
package reseed_pkg;
    localparam int DEF_WORD_W   = 64;
    localparam int DEF_CNT_W    = 16;
    localparam int DEF_INTERVAL = 256;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;
endpackage

// File: rtl/reseed_timer.sv
// Interval timer: counts cycles while run is high and flags expiry
// on the cycle that completes the programmed interval.
// Assumes: interval is stable during a wait; 0 is treated as 1.
module reseed_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] interval,
    output logic             expire
);
    logic [CNT_W-1:0] count;
    logic [CNT_W:0]   next_count;

    // Next count value, one bit wider so the compare never wraps.
    always_comb begin
        next_count = {1'b0, count} + 1'b1;
        expire     = run && (next_count >= {1'b0, interval});
    end

    // Count while running, reset to zero when stopped or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) begin
            count <= '0;
        end else begin
            count <= next_count[CNT_W-1:0];
        end
    end

    // R6: the count never runs past the programmed interval.
    assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count == '0 || count < interval));
endmodule

// File: rtl/reseed_assembler.sv
// Word assembler: keeps the low word of a pair and publishes the
// full value with a one-cycle done pulse when the high word arrives.
// Assumes: take_lo and take_hi are never high together.
module reseed_assembler #(
    parameter int WORD_W = 64,
    localparam int SEED_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take_lo,
    input  logic              take_hi,
    input  logic [WORD_W-1:0] word_in,
    output logic [SEED_W-1:0] seed_out,
    output logic              seed_done
);
    logic [WORD_W-1:0] low_word;

    // Hold the first word of a pair; clear it on abort or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            low_word <= '0;
        end else if (take_lo) begin
            low_word <= word_in;
        end
    end

    // Publish the full value and pulse done when the second word lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_out  <= '0;
            seed_done <= 1'b0;
        end else begin
            seed_done <= take_hi;
            if (take_hi) begin
                seed_out <= {word_in, low_word};
            end
        end
    end

    // R4: done is a single-cycle pulse.
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_done |=> !seed_done);
    // R4: the published value only changes together with done.
    assert_seed_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !take_hi |=> $stable(seed_out));
endmodule

// File: rtl/reseed_fsm.sv
// Sequencer: idle until started, then alternates between fetching a
// pair of words and waiting for the interval timer.
// Assumes: ack is only meaningful while req is high.
module reseed_fsm
    import reseed_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    input  logic ack,
    input  logic expire,
    output logic req,
    output logic run,
    output logic take_lo,
    output logic take_hi,
    output logic clear
);
    phase_e phase;
    logic   second;

    // Decode outputs from the phase and the word tracker.
    always_comb begin
        req     = (phase == PH_FETCH);
        run     = (phase == PH_WAIT);
        take_lo = enable && req && ack && !second;
        take_hi = enable && req && ack && second;
        clear   = !enable || (phase == PH_IDLE && start);
    end

    // Phase and word tracker update; enable low aborts to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase  <= PH_IDLE;
            second <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase  <= PH_FETCH;
                    second <= 1'b0;
                end
                PH_FETCH: if (ack) begin
                    if (second) begin
                        phase  <= PH_WAIT;
                        second <= 1'b0;
                    end else begin
                        second <= 1'b1;
                    end
                end
                PH_WAIT: if (expire) phase <= PH_FETCH;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3: an unanswered request stays raised.
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && req && !ack) |=> req);
    // R5: the second request follows the first acknowledge at once.
    assert_second_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_lo |=> (req && enable) || !enable);
    // R8: disable drops the request in the next cycle.
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !req);
    // R9: a start pulse during a wait does not raise a request.
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expire && start) |=> !req);
endmodule

// File: rtl/reseed_requester.sv
// Top level of the periodic entropy refresh requester: joins the
// sequencer, the interval timer and the word assembler.
// Assumes: entropy handshake synchronous to clk.
module reseed_requester
    import reseed_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int CNT_W  = DEF_CNT_W,
    localparam int SEED_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [CNT_W-1:0]  interval,
    output logic              req,
    input  logic              ack,
    input  logic [WORD_W-1:0] data_in,
    output logic [SEED_W-1:0] seed_out,
    output logic              seed_done
);
    logic run, expire, take_lo, take_hi, clear;

    reseed_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .ack(ack), .expire(expire), .req(req), .run(run),
        .take_lo(take_lo), .take_hi(take_hi), .clear(clear)
    );

    reseed_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run),
        .interval(interval), .expire(expire)
    );

    reseed_assembler #(.WORD_W(WORD_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .clear(clear), .take_lo(take_lo),
        .take_hi(take_hi), .word_in(data_in),
        .seed_out(seed_out), .seed_done(seed_done)
    );

    // R6: timer expiry during a wait raises the next request.
    assert_expire_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && run && expire) |=> req);
    // R7: the timer never runs while a fetch is outstanding.
    assert_timer_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !expire);
endmodule

// File: tb/reseed_requester_bench.sv
module reseed_requester_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b1;
    logic         start = 1'b0;
    logic [15:0]  interval = 16'd5;
    logic         req;
    logic         ack = 1'b0;
    logic [63:0]  data_in = '0;
    logic [127:0] seed_out;
    logic         seed_done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [127:0] exp_q[$];

    always #2 clk = ~clk;

    reseed_requester u_reseed_requester (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .interval(interval), .req(req), .ack(ack), .data_in(data_in),
        .seed_out(seed_out), .seed_done(seed_done)
    );

    task automatic chk(input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: pops the expected value whenever done is seen (R4).
    always @(negedge clk) begin
        cyc++;
        if (rst_n && seed_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected done", seed_out, '0);
            end else begin
                logic [127:0] e;
                e = exp_q.pop_front();
                chk(seed_out == e, "R4 seed value", seed_out, e);
            end
        end
        if (cyc > 150000) begin
            chk(1'b0, "watchdog expired", cyc, 150000);
            finish_run();
        end
    end

    // Driver: answers one pair of requests and queues the expected value.
    task automatic serve_pair(input logic [63:0] lo, input logic [63:0] hi,
                              input int delay, input logic [15:0] iv);
        interval = iv;
        exp_q.push_back({hi, lo});
        for (int w = 0; w < 2; w++) begin
            while (!req) @(negedge clk);
            for (int d = 0; d < delay; d++) begin
                @(negedge clk);
                chk(req == 1'b1, "R3 req held until ack", req, 1);
            end
            ack = 1'b1;
            data_in = (w == 0) ? lo : hi;
            @(negedge clk);
            ack = 1'b0;
            data_in = '0;
            if (w == 0) chk(req == 1'b1, "R5 second request follows", req, 1);
            else chk(!req && seed_done, "R4 done after second ack", seed_done, 1);
        end
    endtask

    // Measures cycles from done to the next request (R6, R7, R9).
    task automatic measure_wait(input int exp_wait, input bit poke_start);
        int k = 0;
        while (!req && k < 400) begin
            @(negedge clk);
            k++;
            if (poke_start && k == 2) start = 1'b1;
            if (poke_start && k == 3) start = 1'b0;
        end
        chk(k == exp_wait, poke_start ? "R9 wait with stray start" : "R6 R7 wait length",
            k, exp_wait);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!req && !seed_done && seed_out == '0, "R1 reset state", {req, seed_done}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (req) chk(1'b0, "R2 request before start", req, 0);
        end
        chk(!req, "R2 idle before start", req, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(req == 1'b1, "R2 start raises req", req, 1);

        serve_pair(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 0, 16'd5);
        measure_wait(5, 1'b0);
        serve_pair(64'hAAAA_5555_AAAA_5555, 64'h5555_AAAA_5555_AAAA, 3, 16'd1);
        measure_wait(1, 1'b0);
        serve_pair(64'h1111_2222_3333_4444, 64'h9999_8888_7777_6666, 1, 16'd0);
        measure_wait(1, 1'b0);
        serve_pair(64'hDEAD_BEEF_0000_0001, 64'hC0FF_EE00_0000_0002, 0, 16'd30);
        measure_wait(30, 1'b1);
        serve_pair(64'h0F0F_0F0F_F0F0_F0F0, 64'h3C3C_C3C3_3C3C_C3C3, 0, 16'd256);
        measure_wait(256, 1'b0);

        // R8: abort after the first word of a pair.
        ack = 1'b1;
        data_in = 64'hBAD0_BAD0_BAD0_BAD0;
        @(negedge clk);
        ack = 1'b0;
        enable = 1'b0;
        @(negedge clk);
        chk(!req, "R8 req dropped on disable", req, 0);
        enable = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (req) chk(1'b0, "R8 request without new start", req, 0);
        end
        chk(seed_out == {64'h3C3C_C3C3_3C3C_C3C3, 64'h0F0F_0F0F_F0F0_F0F0},
            "R8 seed kept after abort", seed_out,
            {64'h3C3C_C3C3_3C3C_C3C3, 64'h0F0F_0F0F_F0F0_F0F0});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(req == 1'b1, "R8 restart raises req", req, 1);
        serve_pair(64'h7777_0000_7777_0000, 64'h0000_7777_0000_7777, 2, 16'd4);
        measure_wait(4, 1'b0);

        chk(exp_q.size() == 0, "R4 all pairs published", exp_q.size(), 0);
        finish_run();
    end
endmodule